// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best candidate as an ID and a priority byte. The block compares that priority against a programmable threshold and raises a level interrupt request to the processor when the candidate qualifies. The processor then completes a handshake through four word registers on a simple request/response bus.

Reading the acknowledge register returns the ID of the qualifying candidate and moves it into the active state. The block reports this to the distributor with a one-cycle strobe, and the distributor clears the line's pending flag. While an interrupt is active, the request line stays low. Writing that same ID to the end-of-interrupt register retires it and sends a one-cycle completion strobe back to the distributor. When no candidate qualifies, the acknowledge read returns the reserved spurious ID 1023 and changes nothing. Only one interrupt can be active at a time, and there is no preemption.

Top module: `irqc_cpu_port`

## Requirements
- R1: After reset, the request line is low, the enable bit and the threshold both read 0, and neither strobe fires.
- R2: Register word address 0 is the control register, and its bit 0 enables signalling. While that bit is 0, the request line is low whatever the candidate.
- R3: Register word address 1 holds the threshold in bits [7:0]. A candidate qualifies only if its priority is strictly below the threshold, so a priority equal to the threshold is masked.
- R4: The request line is high exactly when the block is enabled, a candidate is offered with an ID below 1020, its priority passes the threshold, and no interrupt is active. The line follows a candidate change in the same cycle.
- R5: Reading word address 2 while a candidate qualifies does three things. It returns the candidate ID in bits [9:0], with the upper bits zero. It pulses the acknowledge strobe for one cycle, carrying that ID. It makes the ID active, which lowers the request line.
- R6: Reading word address 2 while nothing qualifies returns 1023, fires no strobe and leaves the active state unchanged.
- R7: A candidate with an ID from 1020 to 1023 never qualifies. It is never signalled and never acknowledged.
- R8: Writing to word address 3 a whole word equal to the active ID does three things. It pulses the completion strobe for one cycle, carrying that ID. It clears the active state. The request line can then rise in the next cycle.
- R9: A write to word address 3 is ignored when no interrupt is active or when the word differs from the active ID. Ignored means no strobe, and the active interrupt still holds the request line low.
- R10: Every read is answered exactly one cycle later by a response valid pulse with the data. Address 3 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower value is more urgent) |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request to the processor |
| ack_stb | output | 1 | One-cycle acknowledge strobe to the distributor |
| ack_id | output | 10 | ID carried by the acknowledge strobe |
| eoi_stb | output | 1 | One-cycle completion strobe to the distributor |
| eoi_id | output | 10 | ID carried by the completion strobe |

## Verification
Two things can meet in one cycle: an acknowledge read, and a change of the candidate inputs on the same clock edge. The bench provokes this by driving a new candidate in the same cycle as the read. The returned ID must then be the candidate sampled at that edge. The other collision is a completion write while a further candidate is already waiting. The bench checks that the request line stays low while the completion is in flight and rises in the very next cycle. Both cases are judged against a behavioural model that is compared with the outputs on every clock, and a randomized phase repeats these collisions with varying thresholds and IDs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SPURIOUS_ID   = 1023;
  localparam int FIRST_RSV_ID  = 1020;
  localparam int REG_CTRL      = 0;
  localparam int REG_THRESH    = 1;
  localparam int REG_ACK       = 2;
  localparam int REG_EOI       = 3;

  typedef struct packed {
    logic rd_ctrl;
    logic rd_thresh;
    logic rd_ack;
    logic rd_any;
    logic wr_ctrl;
    logic wr_thresh;
    logic wr_eoi;
  } bus_dec_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_thresh,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_o,
  output logic [PRIO_W-1:0] thresh_o
);
  logic              en_q, en_d;
  logic [PRIO_W-1:0] th_q, th_d;

  always_comb begin
    en_d = en_q;
    th_d = th_q;
    if (wr_ctrl)   en_d = wdata[0];
    if (wr_thresh) th_d = wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      th_q <= '0;
    end else begin
      if (wr_ctrl)   en_q <= en_d;
      if (wr_thresh) th_q <= th_d;
    end
  end

  assign en_o     = en_q;
  assign thresh_o = th_q;

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (en_o == $past(wdata[0])));
  p_thresh_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thresh |=> (thresh_o == $past(wdata[PRIO_W-1:0])));
endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              en,
  input  logic [PRIO_W-1:0] thresh,
  input  logic              active,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              eligible
);
  localparam logic [ID_W-1:0] RSV_FIRST = ID_W'(irqc_pkg::FIRST_RSV_ID);

  logic id_ok, prio_ok;

  always_comb begin
    id_ok    = cand_id < RSV_FIRST;
    prio_ok  = cand_prio < thresh;
    eligible = en & cand_valid & id_ok & prio_ok & ~active;
  end
endmodule

// File: rtl/irqc_handshake.sv
module irqc_handshake #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  irqc_pkg::bus_dec_t dec,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               eligible,
  input  logic [ID_W-1:0]    cand_id,
  input  logic               en,
  input  logic [PRIO_W-1:0]  thresh,
  output logic               active_o,
  output logic               ack_stb_o,
  output logic [ID_W-1:0]    ack_id_o,
  output logic               eoi_stb_o,
  output logic [ID_W-1:0]    eoi_id_o,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o
);
  localparam logic [ID_W-1:0] SPUR = ID_W'(irqc_pkg::SPURIOUS_ID);
  localparam logic [ID_W-1:0] RSV_FIRST = ID_W'(irqc_pkg::FIRST_RSV_ID);

  logic              act_q, act_d;
  logic [ID_W-1:0]   aid_q, aid_d;
  logic              ack_q, ack_d;
  logic [ID_W-1:0]   ackid_q, ackid_d;
  logic              eoi_q, eoi_d;
  logic [ID_W-1:0]   eoiid_q, eoiid_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              eoi_match;
  logic              state_ce;

  always_comb begin
    eoi_match = dec.wr_eoi & act_q & (wdata == DATA_W'(aid_q));
    act_d   = act_q;
    aid_d   = aid_q;
    ack_d   = 1'b0;
    ackid_d = ackid_q;
    eoi_d   = 1'b0;
    eoiid_d = eoiid_q;
    rv_d    = dec.rd_any;
    rd_d    = rd_q;
    if (dec.rd_any) begin
      rd_d = '0;
      if (dec.rd_ctrl)   rd_d[0] = en;
      if (dec.rd_thresh) rd_d[PRIO_W-1:0] = thresh;
      if (dec.rd_ack) begin
        if (eligible) begin
          rd_d[ID_W-1:0] = cand_id;
          ack_d   = 1'b1;
          ackid_d = cand_id;
          act_d   = 1'b1;
          aid_d   = cand_id;
        end else begin
          rd_d[ID_W-1:0] = SPUR;
        end
      end
    end
    if (eoi_match) begin
      eoi_d   = 1'b1;
      eoiid_d = aid_q;
      act_d   = 1'b0;
    end
    state_ce = dec.rd_ack | eoi_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      aid_q   <= '0;
      ack_q   <= 1'b0;
      ackid_q <= '0;
      eoi_q   <= 1'b0;
      eoiid_q <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      ack_q <= ack_d;
      eoi_q <= eoi_d;
      rv_q  <= rv_d;
      if (state_ce) begin
        act_q <= act_d;
        aid_q <= aid_d;
      end
      if (ack_d)        ackid_q <= ackid_d;
      if (eoi_d)        eoiid_q <= eoiid_d;
      if (dec.rd_any)   rd_q    <= rd_d;
    end
  end

  assign active_o    = act_q;
  assign ack_stb_o   = ack_q;
  assign ack_id_o    = ackid_q;
  assign eoi_stb_o   = eoi_q;
  assign eoi_id_o    = eoiid_q;
  assign rsp_valid_o = rv_q;
  assign rsp_rdata_o = rd_q;

  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb_o |=> !ack_stb_o);
  p_ack_marks_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb_o |-> (active_o && ack_id_o == rsp_rdata_o[ID_W-1:0]));
  p_ack_not_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb_o |-> (ack_id_o < RSV_FIRST));
  p_eoi_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb_o |-> (!active_o && $past(active_o) && eoi_id_o == $past(aid_q)));
  p_eoi_needs_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.wr_eoi && !act_q) |=> !eoi_stb_o);
  p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec.rd_any |=> rsp_valid_o);
  p_spurious_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.rd_ack && !eligible) |=> (!ack_stb_o && rsp_rdata_o[ID_W-1:0] == SPUR));
endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port #(
  parameter int ID_W       = 10,
  parameter int PRIO_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq,
  output logic              ack_stb,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_stb,
  output logic [ID_W-1:0]   eoi_id
);
  import irqc_pkg::*;

  logic              rst_n_s;
  bus_dec_t          dec;
  logic              en;
  logic [PRIO_W-1:0] thresh;
  logic              active;
  logic              eligible;

  irqc_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    logic rd, wr;
    rd = req_valid & ~req_write;
    wr = req_valid &  req_write;
    dec.rd_any    = rd;
    dec.rd_ctrl   = rd & (req_addr == ADDR_W'(REG_CTRL));
    dec.rd_thresh = rd & (req_addr == ADDR_W'(REG_THRESH));
    dec.rd_ack    = rd & (req_addr == ADDR_W'(REG_ACK));
    dec.wr_ctrl   = wr & (req_addr == ADDR_W'(REG_CTRL));
    dec.wr_thresh = wr & (req_addr == ADDR_W'(REG_THRESH));
    dec.wr_eoi    = wr & (req_addr == ADDR_W'(REG_EOI));
  end

  irqc_cfg_regs #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .wr_ctrl(dec.wr_ctrl), .wr_thresh(dec.wr_thresh), .wdata(req_wdata),
    .en_o(en), .thresh_o(thresh)
  );

  irqc_qualify #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_qual (
    .en(en), .thresh(thresh), .active(active),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
    .eligible(eligible)
  );

  irqc_handshake #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_hs (
    .clk(clk), .rst_n(rst_n_s), .dec(dec), .wdata(req_wdata),
    .eligible(eligible), .cand_id(cand_id), .en(en), .thresh(thresh),
    .active_o(active), .ack_stb_o(ack_stb), .ack_id_o(ack_id),
    .eoi_stb_o(eoi_stb), .eoi_id_o(eoi_id),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

  assign irq = eligible;

  p_irq_low_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en |-> !irq);
  p_irq_low_active_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    active |-> !irq);
  p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cand_prio >= thresh) |-> !irq);
  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(ack_stb && eoi_stb));
endmodule

// File: tb/irqc_cpu_port_tb_top.sv
module irqc_cpu_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq, ack_stb, eoi_stb;
  logic [9:0]  ack_id, eoi_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irqc_cpu_port dut_i (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq), .ack_stb(ack_stb), .ack_id(ack_id),
    .eoi_stb(eoi_stb), .eoi_id(eoi_id)
  );

  // Behavioural reference model
  int  m_hold = 0;
  bit  m_en = 0, m_act = 0;
  int  m_th = 0, m_aid = 0;
  bit  m_rv = 0, m_ack = 0, m_eoi = 0;
  int  m_rd = 0, m_ackid = 0, m_eoiid = 0;

  function automatic bit m_elig();
    return m_en && cand_valid && int'(cand_id) < 1020 &&
           int'(cand_prio) < m_th && !m_act;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 2; m_en = 0; m_act = 0; m_th = 0; m_aid = 0;
      m_rv = 0; m_ack = 0; m_eoi = 0;
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      bit e;
      e = m_elig();
      m_rv = 0; m_ack = 0; m_eoi = 0;
      if (req_valid && !req_write) begin
        m_rv = 1;
        case (int'(req_addr))
          0: m_rd = int'(m_en);
          1: m_rd = m_th;
          2: if (e) begin
               m_rd = int'(cand_id); m_ack = 1; m_ackid = int'(cand_id);
               m_act = 1; m_aid = int'(cand_id);
             end else m_rd = 1023;
          default: m_rd = 0;
        endcase
      end else if (req_valid && req_write) begin
        case (int'(req_addr))
          0: m_en = req_wdata[0];
          1: m_th = int'(req_wdata[7:0]);
          3: if (m_act && req_wdata == 32'(m_aid)) begin
               m_eoi = 1; m_eoiid = m_aid; m_act = 0;
             end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      check("R4 irq", int'(irq), int'(m_elig()));
      check("R10 rsp_valid", int'(rsp_valid), int'(m_rv));
      if (m_rv) check("R10 rsp_rdata", int'(rsp_rdata), m_rd);
      check("R5 ack_stb", int'(ack_stb), int'(m_ack));
      if (m_ack) check("R5 ack_id", int'(ack_id), m_ackid);
      check("R8 eoi_stb", int'(eoi_stb), int'(m_eoi));
      if (m_eoi) check("R8 eoi_id", int'(eoi_id), m_eoiid);
    end
  end

  task automatic bus_rd(input int a, output int d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 4'(a);
    @(negedge clk);
    req_valid = 0;
    d = int'(rsp_rdata);
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'(a); req_wdata = 32'(d);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic cand(input bit v, input int id, input int pr);
    @(negedge clk);
    cand_valid = v; cand_id = 10'(id); cand_prio = 8'(pr);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    bus_rd(0, d); check("R1 ctrl", d, 0);
    bus_rd(1, d); check("R1 thresh", d, 0);
    // R2 disabled keeps line low
    bus_wr(1, 32'h1F0);
    cand(1, 45, 8'h80);
    @(negedge clk); check("R2 disabled", int'(irq), 0);
    bus_wr(0, 1);
    @(negedge clk); check("R4 raised", int'(irq), 1);
    // R3 equality masks
    bus_wr(1, 8'h80); @(negedge clk); check("R3 equal", int'(irq), 0);
    bus_wr(1, 8'h81); @(negedge clk); check("R3 below", int'(irq), 1);
    // R5 acknowledge
    bus_rd(2, d); check("R5 id", d, 45);
    check("R5 irq low", int'(irq), 0);
    // R6 spurious while active
    bus_rd(2, d); check("R6 spurious", d, 1023);
    // R9 mismatching completions
    bus_wr(3, 46); check("R9 irq low", int'(irq), 0);
    bus_wr(3, 32'h0000_042D); check("R9 upper bits", int'(irq), 0);
    bus_wr(3, 1023);
    // R8 matching completion, waiting candidate re-raises next cycle
    bus_wr(3, 45); check("R8 re-raise", int'(irq), 1);
    // R7 reserved IDs
    cand(1, 1021, 0);
    @(negedge clk); check("R7 irq", int'(irq), 0);
    bus_rd(2, d); check("R7 ack", d, 1023);
    // candidate change in the same cycle as the acknowledge read
    @(negedge clk);
    cand_valid = 1; cand_id = 10'd77; cand_prio = 8'h10;
    req_valid = 1; req_write = 0; req_addr = 4'd2;
    @(negedge clk); req_valid = 0; d = int'(rsp_rdata);
    check("R5 same-cycle id", d, 77);
    bus_wr(3, 77);
    // R10 unused address reads zero
    bus_rd(3, d); check("R10 eoi reads 0", d, 0);
    bus_rd(9, d); check("R10 unused", d, 0);
    // randomized phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) cand(1'($urandom_range(0, 1)),
                       (op == 0) ? int'($urandom_range(1018, 1023)) : int'($urandom_range(0, 60)),
                       int'($urandom_range(0, 255)));
      else if (op < 5) bus_rd(2, d);
      else if (op == 5) bus_wr(3, m_act && $urandom_range(0, 3) != 0 ? m_aid : int'($urandom_range(0, 1023)));
      else if (op == 6) bus_wr(1, int'($urandom_range(0, 255)));
      else if (op == 7) bus_wr(0, int'($urandom_range(0, 7)) == 0 ? 0 : 1);
      else if (op == 8) bus_rd(int'($urandom_range(0, 4)), d);
      else @(negedge clk);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule